// File: doc/BRIEF.md
# Truncated Constant-Coefficient FIR Filter

This block is a direct-form FIR filter whose signed coefficients are fixed when it is elaborated. Each accepted input sample enters a tap delay line. Every tap product is split into partial-product bits, and all of those bits from all taps go into one shared bit matrix. A tree of 3:2 carry-save adders reduces that matrix to two rows, and one carry-propagate adder adds those two rows. Only the upper P bits of the sum reach the output. To save area, the low-order columns that cannot affect those P bits are never built.

Sign extension of the partial-product rows is avoided by inverting each row's sign bit. The sum of all correction terms goes into one constant row. The same constant row also carries a compensation term for the deleted columns and a rounding half-unit. The result is that the output stays within one output unit of the exact sum.

Samples enter and results leave over a valid/ready stream. The pipeline advances only when its output register is empty or is being read. When the consumer holds off, the whole pipeline freezes and the input is refused.

Top module: `trunc_fir`

## Requirements
- R1: Let S be the exact sum over taps i of a_i·x[n−i], with x and a taken as two's-complement integers. Let W = XW + CW + ceil(log2 TAPS) and SHIFT = W − P. Each output value y (P-bit two's complement) then satisfies |y·2^SHIFT − S| ≤ 2^SHIFT.
- R2: Coefficient a_i is the CW-bit field at bits [i·CW +: CW] of COEFS. It multiplies the sample accepted i transfers before the newest one, so tap 0 is the newest sample. A single nonzero sample followed by zeros therefore gives outputs that trace the coefficients in tap order.
- R3: The delay line shifts only on an input transfer (in_valid and in_ready both high at a rising edge). Idle cycles, and samples offered while in_ready is low, leave the history unchanged.
- R4: Suppose a sample is transferred at edge k into an empty pipeline, with out_ready held high. Then out_valid is low after edges k and k+1, and its result is presented with out_valid high after edge k+2.
- R5: While out_valid is high and out_ready is low, out_valid and out_data keep their values at the next edge, and in_ready is low.
- R6: in_ready is high whenever out_valid is low or out_ready is high.
- R7: Synchronous reset drives out_valid low and clears the history. After reset, in_ready is high, and outputs are computed as if all earlier samples were zero.
- R8: An input of −128 combined with a coefficient of −128, and all-extreme input patterns aligned to the coefficient signs, still meet the R1 bound without wrap-around.
- R9: The carry-save reduction preserves the total of the retained matrix bits modulo 2^W, so its two rows always add to the same value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample is offered |
| in_ready | output | 1 | Block takes the offered sample at this edge |
| in_data | input | XW | Input sample, two's complement |
| out_valid | output | 1 | Output result is presented |
| out_ready | input | 1 | Consumer takes the presented result |
| out_data | output | P | Upper P bits of the filter sum, two's complement |

## Verification
Without a stall, each accepted sample's result appears two rising edges after the edge that accepted it. A stall postpones it by exactly the number of held cycles, and the result stays on the port throughout. The bench drives and samples only at falling edges. On each falling edge it decides whether a transfer happens at the next rising edge on each side. It pushes a model result into an ordered queue for every accepted sample and pops one only when it sees an output transfer, so checks land on the cycle each result is actually taken. The latency scenario counts falling edges after a single accepted sample, and the back-pressure scenario checks the held output on every stalled cycle.

// File: rtl/trunc_fir_pkg.sv
package trunc_fir_pkg;

  // Row count after one layer of 3:2 compression.
  function automatic int next_rows(input int n);
    return (n / 3) * 2 + (n % 3);
  endfunction

  // Row count entering layer l of the tree.
  function automatic int rows_at(input int n, input int l);
    int r;
    r = n;
    for (int i = 0; i < l; i++) r = next_rows(r);
    return r;
  endfunction

  // Layers needed to reach two rows.
  function automatic int tree_levels(input int n);
    int r;
    int c;
    r = n;
    c = 0;
    while (r > 2) begin
      r = next_rows(r);
      c++;
    end
    return c;
  endfunction

endpackage

// File: rtl/trunc_fir_taps.sv
module trunc_fir_taps #(
  parameter int TAPS = 8,
  parameter int XW   = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       shift_i,
  input  logic [XW-1:0]              din_i,
  output logic [TAPS-1:0][XW-1:0]    line_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      line_o <= '0;
    end else if (shift_i) begin
      line_o <= {line_o[TAPS-2:0], din_i};
    end
  end

  AST_LINE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !shift_i |=> $stable(line_o)); // R3

  AST_NEWEST_TAP: assert property (@(posedge clk) disable iff (rst)
    shift_i |=> line_o[0] == $past(din_i)); // R2

endmodule

// File: rtl/trunc_fir_ppm.sv
module trunc_fir_ppm #(
  parameter int TAPS  = 8,
  parameter int XW    = 8,
  parameter int CW    = 8,
  parameter int W     = 19,
  parameter int SHIFT = 7,
  parameter logic [TAPS*CW-1:0] COEFS = '0
) (
  input  logic [TAPS-1:0][XW-1:0]   line_i,
  output logic [TAPS*XW:0][W-1:0]   rows_o
);

  // Constant for the row of tap t and input bit j, CW+1 bits wide.
  // The sign bit of x carries negative weight, so its row uses -a.
  function automatic logic [CW:0] row_const(input int t, input int j);
    logic [CW:0] a;
    a = {COEFS[t*CW+CW-1], COEFS[t*CW +: CW]};
    return (j == XW-1) ? -a : a;
  endfunction

  // Largest value the variable bits below column d can hold.
  function automatic longint drop_max(input int d);
    longint e;
    logic [CW:0] c;
    e = 0;
    for (int t = 0; t < TAPS; t++) begin
      for (int j = 0; j < XW; j++) begin
        c = row_const(t, j);
        for (int k = 0; k <= CW; k++) begin
          if (c[k] && (j + k) < d) e = e + (longint'(1) << (j + k));
        end
      end
    end
    return e;
  endfunction

  // Widest deletion whose worst-case loss is still one output unit.
  function automatic int del_cols();
    int d;
    d = 0;
    while (d < SHIFT && drop_max(d + 1) <= (longint'(1) << SHIFT)) d++;
    return d;
  endfunction

  localparam int DEL = del_cols();

  // Single constant row: sign corrections, deletion compensation, rounding.
  function automatic logic [W-1:0] bias_row();
    longint b;
    logic [CW:0] c;
    b = (SHIFT > 0) ? (longint'(1) << (SHIFT - 1)) : 0;
    b = b + drop_max(DEL) / 2;
    for (int t = 0; t < TAPS; t++) begin
      for (int j = 0; j < XW; j++) begin
        c = row_const(t, j);
        if (c[CW]) b = b - (longint'(1) << (j + CW));
      end
    end
    return b[W-1:0];
  endfunction

  localparam logic [W-1:0] BIAS = bias_row();

  always_comb begin
    rows_o = '0;
    for (int t = 0; t < TAPS; t++) begin
      for (int j = 0; j < XW; j++) begin
        automatic logic [CW:0] c = row_const(t, j);
        for (int k = 0; k < CW; k++) begin
          if (c[k] && (j + k) >= DEL) rows_o[t*XW+j][j+k] = line_i[t][j];
        end
        if (c[CW] && (j + CW) >= DEL) rows_o[t*XW+j][j+CW] = ~line_i[t][j];
      end
    end
    rows_o[TAPS*XW] = BIAS;
  end

endmodule

// File: rtl/trunc_fir_csa.sv
module trunc_fir_csa
  import trunc_fir_pkg::*;
#(
  parameter int N = 65,
  parameter int W = 19
) (
  input  logic [N-1:0][W-1:0] rows_i,
  output logic [W-1:0]        sum_o,
  output logic [W-1:0]        carry_o
);

  localparam int NLEV = tree_levels(N);

  for (genvar l = 0; l < NLEV; l++) begin : g_lv
    localparam int NI = rows_at(N, l);
    localparam int NO = next_rows(NI);
    localparam int NG = NI / 3;

    logic [W-1:0] ri [NI];
    logic [W-1:0] ro [NO];

    for (genvar r = 0; r < NI; r++) begin : g_src
      if (l == 0) begin : g_top
        assign ri[r] = rows_i[r];
      end else begin : g_prev
        assign ri[r] = g_lv[l-1].ro[r];
      end
    end

    for (genvar g = 0; g < NG; g++) begin : g_fa
      assign ro[2*g]   = ri[3*g] ^ ri[3*g+1] ^ ri[3*g+2];
      assign ro[2*g+1] = ((ri[3*g] & ri[3*g+1]) | (ri[3*g] & ri[3*g+2]) |
                          (ri[3*g+1] & ri[3*g+2])) << 1;
    end

    for (genvar r = 3*NG; r < NI; r++) begin : g_pass
      assign ro[2*NG + r - 3*NG] = ri[r];
    end
  end

  assign sum_o   = g_lv[NLEV-1].ro[0];
  assign carry_o = g_lv[NLEV-1].ro[1];

endmodule

// File: rtl/trunc_fir.sv
module trunc_fir #(
  parameter int TAPS = 8,
  parameter int XW   = 8,
  parameter int CW   = 8,
  parameter int P    = 12,
  parameter logic [TAPS*CW-1:0] COEFS = 64'h01B3_1900_FD40_7F80
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [XW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [P-1:0]  out_data
);

  localparam int W     = XW + CW + $clog2(TAPS);
  localparam int SHIFT = W - P;
  localparam int NR    = TAPS * XW + 1;
  localparam logic signed [W+1:0] ULP = (W+2)'(1) <<< SHIFT;

  logic                     adv;
  logic                     take;
  logic [TAPS-1:0][XW-1:0]  line;
  logic [NR-1:0][W-1:0]     rows;
  logic [W-1:0]             cs_s, cs_c;
  logic [W-1:0]             s_q, c_q;
  logic                     v1, v2;
  logic [P-1:0]             y_c;

  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;
  assign take     = in_valid && adv;

  trunc_fir_taps #(.TAPS(TAPS), .XW(XW)) u_taps (
    .clk(clk), .rst(rst), .shift_i(take), .din_i(in_data), .line_o(line)
  );

  trunc_fir_ppm #(
    .TAPS(TAPS), .XW(XW), .CW(CW), .W(W), .SHIFT(SHIFT), .COEFS(COEFS)
  ) u_ppm (
    .line_i(line), .rows_o(rows)
  );

  trunc_fir_csa #(.N(NR), .W(W)) u_csa (
    .rows_i(rows), .sum_o(cs_s), .carry_o(cs_c)
  );

  assign y_c = P'((s_q + c_q) >> SHIFT);

  always_ff @(posedge clk) begin
    if (rst) begin
      v1        <= 1'b0;
      v2        <= 1'b0;
      out_valid <= 1'b0;
      s_q       <= '0;
      c_q       <= '0;
      out_data  <= '0;
    end else if (adv) begin
      v1        <= take;
      v2        <= v1;
      s_q       <= cs_s;
      c_q       <= cs_c;
      out_valid <= v2;
      out_data  <= y_c;
    end
  end

  // Reference values kept beside the carry-save pair for the checks below.
  logic signed [W:0]   exact_c, exact_q;
  logic [W-1:0]        mat_c, mat_q;
  logic signed [W+1:0] pair_ext, diff;

  always_comb begin
    exact_c = '0;
    mat_c   = '0;
    for (int t = 0; t < TAPS; t++) begin
      exact_c = exact_c + (W+1)'($signed(line[t])) *
                          (W+1)'($signed(COEFS[t*CW +: CW]));
    end
    for (int r = 0; r < NR; r++) mat_c = mat_c + rows[r];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      exact_q <= '0;
      mat_q   <= '0;
    end else if (adv) begin
      exact_q <= exact_c;
      mat_q   <= mat_c;
    end
  end

  assign pair_ext = {{(W+2-P){y_c[P-1]}}, y_c} << SHIFT;
  assign diff     = pair_ext - $signed({exact_q[W], exact_q});

  AST_CSA_CONSERVES: assert property (@(posedge clk) disable iff (rst)
    v2 |-> (s_q + c_q) == mat_q); // R9

  AST_ERR_BOUND: assert property (@(posedge clk) disable iff (rst)
    v2 |-> (diff <= ULP && diff >= -ULP)); // R1

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R5

  AST_VALID_SOURCE: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(v2)); // R4

endmodule

// File: tb/trunc_fir_tb.sv
module trunc_fir_tb;

  localparam int TAPS = 8;
  localparam int XW   = 8;
  localparam int CW   = 8;
  localparam int P    = 12;
  localparam int W    = XW + CW + $clog2(TAPS);
  localparam int SH   = W - P;
  localparam int ULP  = 1 << SH;
  localparam logic [TAPS*CW-1:0] CF = 64'h01B3_1900_FD40_7F80;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          out_ready = 1'b0;
  logic [XW-1:0] in_data = '0;
  logic          in_ready;
  logic          out_valid;
  logic [P-1:0]  out_data;

  int    total = 0;
  int    bad = 0;
  int    hist[TAPS];
  int    expq[$];
  string tag = "R7";
  bit    chk_rdy = 1'b0;
  bit    done = 1'b0;

  trunc_fir #(.TAPS(TAPS), .XW(XW), .CW(CW), .P(P), .COEFS(CF)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  always #2 clk = ~clk;

  function automatic int coef(input int i);
    return int'($signed(CF[i*CW +: CW]));
  endfunction

  function automatic int model_sum();
    int s;
    s = 0;
    for (int i = 0; i < TAPS; i++) s = s + hist[i] * coef(i);
    return s;
  endfunction

  task automatic check(input bit ok, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int i = 0; i < TAPS; i++) hist[i] = 0;
    expq.delete();
  endtask

  // One cycle, entered and left at a falling edge.
  task automatic step(input bit v, input logic [XW-1:0] d, input bit rdy);
    int s;
    int y;
    int df;
    in_valid  = v;
    in_data   = d;
    out_ready = rdy;
    #1;
    if (chk_rdy)
      check(in_ready == (!out_valid || out_ready), "in_ready",
            int'(in_ready), int'(!out_valid || out_ready));
    if (out_valid && out_ready) begin
      y = int'($signed(out_data));
      if (expq.size() == 0) begin
        check(1'b0, "unexpected output", y, 0);
      end else begin
        s  = expq.pop_front();
        df = y * ULP - s;
        check(df <= ULP && df >= -ULP, "output", y, (s + ULP / 2) >>> SH);
      end
    end
    if (in_valid && in_ready) begin
      for (int i = TAPS - 1; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = int'($signed(d));
      expq.push_back(model_sum());
    end
    @(negedge clk);
  endtask

  task automatic drain();
    for (int i = 0; i < 24 && expq.size() > 0; i++) step(1'b0, '0, 1'b1);
    check(expq.size() == 0, "missing outputs", expq.size(), 0);
    step(1'b0, '0, 1'b1);
    step(1'b0, '0, 1'b1);
  endtask

  task automatic t_impulse();
    tag = "R2";
    step(1'b1, 8'h7F, 1'b1);
    for (int i = 0; i < TAPS; i++) step(1'b1, 8'h00, 1'b1);
    step(1'b1, 8'h81, 1'b1);
    for (int i = 0; i < TAPS; i++) step(1'b1, 8'h00, 1'b1);
    drain();
  endtask

  task automatic t_gaps();
    tag = "R3";
    for (int i = 0; i < 16; i++) begin
      step(1'b1, XW'($urandom), 1'b1);
      for (int g = 0; g < i % 3; g++) step(1'b0, XW'($urandom), 1'b1);
    end
    drain();
  endtask

  task automatic t_latency();
    tag = "R4";
    step(1'b1, 8'd55, 1'b1);
    check(out_valid == 1'b0, "valid after accept edge", int'(out_valid), 0);
    step(1'b0, '0, 1'b1);
    check(out_valid == 1'b0, "valid one edge later", int'(out_valid), 0);
    step(1'b0, '0, 1'b1);
    check(out_valid == 1'b1, "valid two edges later", int'(out_valid), 1);
    drain();
  endtask

  task automatic t_backpressure();
    logic [P-1:0] held;
    tag = "R5";
    step(1'b1, 8'd10, 1'b0);
    step(1'b1, 8'd20, 1'b0);
    step(1'b1, 8'd30, 1'b0);
    check(out_valid == 1'b1, "valid at stall start", int'(out_valid), 1);
    held = out_data;
    for (int i = 0; i < 4; i++) begin
      step(1'b1, 8'd99, 1'b0);
      check(out_valid == 1'b1 && out_data == held, "held output",
            int'(out_data), int'(held));
      check(in_ready == 1'b0, "in_ready during stall", int'(in_ready), 0);
    end
    drain();
  endtask

  task automatic t_extreme();
    tag = "R8";
    for (int i = 0; i <= TAPS; i++) step(1'b1, 8'h80, 1'b1);
    for (int i = 0; i <= TAPS; i++) step(1'b1, 8'h7F, 1'b1);
    for (int i = TAPS - 1; i >= 0; i--)
      step(1'b1, (coef(i) < 0) ? 8'h80 : 8'h7F, 1'b1);
    for (int i = TAPS - 1; i >= 0; i--)
      step(1'b1, (coef(i) < 0) ? 8'h7F : 8'h80, 1'b1);
    drain();
  endtask

  task automatic t_random();
    tag = "R1/R9";
    for (int i = 0; i < 300; i++) step(1'b1, XW'($urandom), 1'b1);
    drain();
  endtask

  task automatic t_flow();
    tag = "R6";
    chk_rdy = 1'b1;
    for (int i = 0; i < 300; i++)
      step(1'($urandom), XW'($urandom), ($urandom % 4) != 0);
    chk_rdy = 1'b0;
    drain();
  endtask

  task automatic t_reset_mid();
    tag = "R7";
    for (int i = 0; i < 6; i++) step(1'b1, XW'($urandom), 1'b1);
    rst = 1'b1;
    in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    clear_model();
    check(out_valid == 1'b0, "out_valid after reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "in_ready after reset", int'(in_ready), 1);
    for (int i = 0; i < 3; i++) step(1'b1, 8'h7F, 1'b1);
    drain();
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    clear_model();
    repeat (3) @(negedge clk);
    tag = "R7";
    check(out_valid == 1'b0, "out_valid in reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "in_ready in reset", int'(in_ready), 1);
    rst = 1'b0;
    @(negedge clk);
    t_impulse();
    t_gaps();
    t_latency();
    t_backpressure();
    t_extreme();
    t_random();
    t_flow();
    t_reset_mid();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

endmodule